// File: doc/BRIEF.md
# Hitless Reference-Switch Recovery Sequencer

This controller supervises how a clock PLL recovers after its reference is disturbed or reselected. It stays idle until the loop reports lock for the first time, and then arms. Once armed, a loss-of-lock indication starts a fixed recovery sequence. The sequencer first gates the phase detector and forces the loop into narrow bandwidth. It can then move the feedback clock by a whole number of oscillator cycles, so that the feedback edge lines up with the new reference phase. After that it re-enables the detector and waits for a run of consecutive in-window comparisons. A fixed settling timer follows, and then wide bandwidth is restored and the sequence re-arms.

The PLL datapath supplies three inputs: the loss-of-lock flag, a per-clock in-window indication from the lock detector, and the measured phase offset between the new reference and the feedback clock. The measured offset is an unsigned number of oscillator cycles with `FRAC_W` fractional bits. The feedback divider adds the accumulated offset output as extra delay. The narrow-bandwidth output drives the loop-filter resistor select. That select also follows an external narrow-bandwidth request at any time.

The qualification length and the settling time are parameters, counted in controller clocks. At 250 MHz, 175 ns rounds up to 44 clocks. The build-out step can be removed with a parameter bit.

Top module: `refsw_seq`

## Requirements
- R1: Under reset the state reads IDLE (code 0), `armed_o` is 0, `pd_en_o` is 1 and the offset is 0. While in IDLE, a high loss-of-lock flag keeps the state in IDLE and starts no sequence.
- R2: In IDLE, the first clock edge that samples the loss-of-lock flag low moves the state to ARMED (code 1), and `armed_o` becomes 1.
- R3: In ARMED, an edge that samples the loss-of-lock flag high moves the state to HOLD (code 2). In HOLD, `pd_en_o` is 0 and `nbw_o` is 1.
- R4: HOLD lasts exactly one clock. The state then becomes QUAL (code 3), with `pd_en_o` back at 1.
- R5: With build-out enabled, the edge that leaves HOLD loads the offset with (previous offset + (round-half-up of the measured phase to whole cycles) mod `FB_LEN`) mod `FB_LEN`. The offset holds its value at all other times and always stays below `FB_LEN`.
- R6: With build-out disabled, the offset stays 0 through every sequence, and the state sequence is the same as with build-out enabled.
- R7: While `nbw_req_i` is 1, `nbw_o` is 1 in every state, within the same cycle.
- R8: In QUAL, the edge that samples the in-window input high for the `QUAL_CYCLES`-th consecutive time moves the state to TIMER (code 4). A sample that is out of window resets the run to zero.
- R9: TIMER lasts exactly `WBW_TICKS` clocks with `nbw_o` forced to 1. The state then returns to ARMED, and `nbw_o` equals `nbw_req_i` again.
- R10: After it returns to ARMED, a new loss of lock starts a new sequence in the same way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lol_i | input | 1 | Loss-of-lock flag from the lock detector |
| edge_ok_i | input | 1 | This cycle's edge error is within the lock window |
| phase_meas_i | input | MEAS_W | Measured reference-to-feedback phase, in oscillator cycles with FRAC_W fractional bits |
| nbw_req_i | input | 1 | External narrow-bandwidth request |
| pd_en_o | output | 1 | Phase detector enable |
| nbw_o | output | 1 | Narrow loop bandwidth select |
| fb_ofs_o | output | OFS_W | Accumulated feedback edge offset, in oscillator cycles |
| armed_o | output | 1 | Sequence is armed |
| state_o | output | 3 | Current sequencer state code |

## Verification
Every state change and every offset update appears one clock edge after the sample that causes it. The bench drives inputs 1 ns after a rising edge and checks the outputs before the next edge, so each check sees the result of exactly one edge. `nbw_o` follows `nbw_req_i` within the same cycle, so the bench checks it right after changing the request. The bench predicts the exit from QUAL by counting consecutive in-window samples edge by edge. It then expects `WBW_TICKS-1` TIMER readings and ARMED on the next edge. A second instance with build-out disabled runs in lockstep, to show that its offset does not move while its states match.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [2:0] {
        HS_IDLE  = 3'd0,
        HS_ARMED = 3'd1,
        HS_HOLD  = 3'd2,
        HS_QUAL  = 3'd3,
        HS_TIMER = 3'd4
    } hs_state_e;

endpackage

// File: rtl/hs_step_cnt.sv
// Counts consecutive qualifying cycles while run_i is high; done_o flags the
// cycle that completes LIMIT of them. Any miss or leaving run clears the count.
module hs_step_cnt #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic hit_i,
    output logic done_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          last;

    assign last   = (cnt_q == CW'(LIMIT - 1));
    assign done_o = run_i && hit_i && last;

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i || !hit_i || last) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/hs_pbo_calc.sv
// Rounds the measured phase to whole oscillator cycles and folds it into the
// accumulated feedback offset, modulo the feedback divider length.
module hs_pbo_calc #(
    parameter int MEAS_W = 8,
    parameter int FRAC_W = 2,
    parameter int FB_LEN = 33,
    parameter int OFS_W  = 6
) (
    input  logic [MEAS_W-1:0] meas_i,
    input  logic [OFS_W-1:0]  ofs_i,
    output logic [OFS_W-1:0]  ofs_o
);
    localparam int SW   = MEAS_W + 1;
    localparam int HALF = (FRAC_W > 0) ? (1 << (FRAC_W - 1)) : 0;

    logic [SW-1:0]    biased;
    logic [SW-1:0]    whole;
    logic [SW-1:0]    wrapped;
    logic [OFS_W:0]   total;

    always_comb begin
        biased  = {1'b0, meas_i} + SW'(HALF);
        whole   = biased >> FRAC_W;
        wrapped = whole % SW'(FB_LEN);
        total   = {1'b0, ofs_i} + {1'b0, wrapped[OFS_W-1:0]};
        if (total >= (OFS_W + 1)'(FB_LEN)) begin
            total = total - (OFS_W + 1)'(FB_LEN);
        end
        ofs_o = total[OFS_W-1:0];
    end

endmodule

// File: rtl/refsw_seq.sv
module refsw_seq
    import hs_pkg::*;
#(
    parameter int QUAL_CYCLES = 8,
    parameter int WBW_TICKS   = 44,
    parameter bit PBO_EN      = 1'b1,
    parameter int MEAS_W      = 8,
    parameter int FRAC_W      = 2,
    parameter int FB_LEN      = 33,
    parameter int OFS_W       = $clog2(FB_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lol_i,
    input  logic              edge_ok_i,
    input  logic [MEAS_W-1:0] phase_meas_i,
    input  logic              nbw_req_i,
    output logic              pd_en_o,
    output logic              nbw_o,
    output logic [OFS_W-1:0]  fb_ofs_o,
    output logic              armed_o,
    output logic [2:0]        state_o
);

    typedef struct packed {
        hs_state_e        st;
        logic [OFS_W-1:0] ofs;
    } seq_t;

    seq_t             seq_d, seq_q;
    logic             qual_done;
    logic             wbw_done;
    logic [OFS_W-1:0] ofs_upd;
    logic             recovering;

    hs_step_cnt #(.LIMIT(QUAL_CYCLES)) u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (seq_q.st == HS_QUAL),
        .hit_i  (edge_ok_i),
        .done_o (qual_done)
    );

    hs_step_cnt #(.LIMIT(WBW_TICKS)) u_wbw (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (seq_q.st == HS_TIMER),
        .hit_i  (1'b1),
        .done_o (wbw_done)
    );

    generate
        if (PBO_EN) begin : g_pbo
            hs_pbo_calc #(
                .MEAS_W (MEAS_W),
                .FRAC_W (FRAC_W),
                .FB_LEN (FB_LEN),
                .OFS_W  (OFS_W)
            ) u_calc (
                .meas_i (phase_meas_i),
                .ofs_i  (seq_q.ofs),
                .ofs_o  (ofs_upd)
            );
        end else begin : g_no_pbo
            assign ofs_upd = seq_q.ofs;
        end
    endgenerate

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            HS_IDLE:  if (!lol_i) seq_d.st = HS_ARMED;
            HS_ARMED: if (lol_i)  seq_d.st = HS_HOLD;
            HS_HOLD: begin
                seq_d.st  = HS_QUAL;
                seq_d.ofs = ofs_upd;
            end
            HS_QUAL:  if (qual_done) seq_d.st = HS_TIMER;
            HS_TIMER: if (wbw_done)  seq_d.st = HS_ARMED;
            default:  seq_d.st = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: HS_IDLE, ofs: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign recovering = (seq_q.st == HS_HOLD) || (seq_q.st == HS_QUAL) ||
                        (seq_q.st == HS_TIMER);
    assign pd_en_o    = (seq_q.st != HS_HOLD);
    assign nbw_o      = nbw_req_i || recovering;
    assign fb_ofs_o   = seq_q.ofs;
    assign armed_o    = (seq_q.st == HS_ARMED);
    assign state_o    = seq_q.st;

endmodule

// File: rtl/refsw_seq_chk.sv
module refsw_seq_chk
    import hs_pkg::*;
#(
    parameter int FB_LEN = 33,
    parameter int OFS_W  = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lol_i,
    input logic             nbw_req_i,
    input logic             pd_en_o,
    input logic             nbw_o,
    input logic [OFS_W-1:0] fb_ofs_o,
    input logic [2:0]       state_o
);

    assert_idle_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == HS_IDLE && lol_i) |=> (state_o == HS_IDLE));

    assert_lol_gates_pd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == HS_ARMED && lol_i) |=> (!pd_en_o && nbw_o));

    assert_hold_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == HS_HOLD) |=> (state_o == HS_QUAL && pd_en_o));

    assert_ofs_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != HS_HOLD) |=> $stable(fb_ofs_o));

    assert_ofs_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(fb_ofs_o) < FB_LEN));

    assert_req_forces_nbw_R7: assert property (@(posedge clk) disable iff (!rst_n)
        nbw_req_i |-> nbw_o);

    assert_timer_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == HS_TIMER) |=> (state_o == HS_TIMER || state_o == HS_ARMED));

endmodule

bind refsw_seq refsw_seq_chk #(.FB_LEN(FB_LEN), .OFS_W(OFS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lol_i     (lol_i),
    .nbw_req_i (nbw_req_i),
    .pd_en_o   (pd_en_o),
    .nbw_o     (nbw_o),
    .fb_ofs_o  (fb_ofs_o),
    .state_o   (state_o)
);

// File: tb/sim_refsw_seq.sv
`timescale 1ns/1ps
module sim_refsw_seq;

    localparam int QC   = 8;
    localparam int WT   = 44;
    localparam int FBL  = 33;
    localparam int OW   = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lol = 1'b1;
    logic          ok = 1'b0;
    logic [7:0]    meas = '0;
    logic          req = 1'b0;

    logic          pd0, nbw0, arm0, pd1, nbw1, arm1;
    logic [OW-1:0] ofs0, ofs1;
    logic [2:0]    st0, st1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    refsw_seq #(.QUAL_CYCLES(QC), .WBW_TICKS(WT), .PBO_EN(1'b1),
                .MEAS_W(8), .FRAC_W(2), .FB_LEN(FBL)) u0 (
        .clk(clk), .rst_n(rst_n), .lol_i(lol), .edge_ok_i(ok),
        .phase_meas_i(meas), .nbw_req_i(req), .pd_en_o(pd0), .nbw_o(nbw0),
        .fb_ofs_o(ofs0), .armed_o(arm0), .state_o(st0));

    refsw_seq #(.QUAL_CYCLES(QC), .WBW_TICKS(WT), .PBO_EN(1'b0),
                .MEAS_W(8), .FRAC_W(2), .FB_LEN(FBL)) u1 (
        .clk(clk), .rst_n(rst_n), .lol_i(lol), .edge_ok_i(ok),
        .phase_meas_i(meas), .nbw_req_i(req), .pd_en_o(pd1), .nbw_o(nbw1),
        .fb_ofs_o(ofs1), .armed_o(arm1), .state_o(st1));

    function automatic int next_ofs(int prev, int m);
        return (prev + (((m + 2) >> 2) % FBL)) % FBL;
    endfunction

    task automatic chk(string req_tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req_tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int exp_ofs;
        void'($urandom(32'h5a17));
        tick(); tick();
        // R1: reset values
        chk("R1 state", int'(st0), 0);
        chk("R1 armed", int'(arm0), 0);
        chk("R1 pd_en", int'(pd0), 1);
        chk("R1 ofs", int'(ofs0), 0);
        rst_n = 1'b1;
        // R1: loss of lock before first lock starts nothing
        for (int i = 0; i < 5; i++) begin
            tick();
            chk("R1 idle under lol", int'(st0), 0);
            chk("R1 pd_en idle", int'(pd0), 1);
        end
        lol = 1'b0;
        tick();
        chk("R2 armed state", int'(st0), 1);
        chk("R2 armed flag", int'(arm0), 1);
        req = 1'b1; #0.5;
        chk("R7 request in ARMED", int'(nbw0), 1);
        req = 1'b0; #0.5;
        chk("R7 wide when no request", int'(nbw0), 0);

        exp_ofs = 0;
        for (int t = 0; t < 14; t++) begin
            int m;
            int run;
            bit reached;
            m    = (t == 1) ? 255 : (t == 2) ? 1 : int'($urandom % 256);
            req  = (t % 4 == 3);
            lol  = 1'b1;
            meas = m[7:0];
            tick();
            chk("R3 hold state", int'(st0), 2);
            chk("R3 pd gated", int'(pd0), 0);
            chk("R3 narrow", int'(nbw0), 1);
            if (t > 0) chk("R10 rearmed sequence", int'(st0), 2);
            lol = 1'b0;
            tick();
            exp_ofs = next_ofs(exp_ofs, m);
            chk("R4 qual state", int'(st0), 3);
            chk("R4 pd enabled", int'(pd0), 1);
            chk("R5 build-out offset", int'(ofs0), exp_ofs);
            chk("R6 offset unchanged", int'(ofs1), 0);
            meas = 8'($urandom);
            run = 0;
            reached = 1'b0;
            for (int k = 0; k < 200 && !reached; k++) begin
                ok = (t == 0) ? (k != 7) : (($urandom % 5) != 0);
                tick();
                run = ok ? run + 1 : 0;
                if (run == QC) begin
                    reached = 1'b1;
                    chk("R8 enter timer", int'(st0), 4);
                end else begin
                    chk("R8 still qualifying", int'(st0), 3);
                end
                chk("R6 same states", int'(st1), int'(st0));
            end
            ok = 1'b0;
            for (int i = 1; i < WT; i++) begin
                tick();
                chk("R9 timer running", int'(st0), 4);
            end
            chk("R9 narrow in timer", int'(nbw0), 1);
            tick();
            chk("R9 back to armed", int'(st0), 1);
            chk("R9 bandwidth follows request", int'(nbw0), int'(req));
            chk("R5 offset held", int'(ofs0), exp_ofs);
            chk("R6 offset still zero", int'(ofs1), 0);
            chk("R6 armed too", int'(arm1), 1);
            tick();
        end
        summary();
    end

endmodule